// File: doc/BRIEF.md
# Bank-Echo Memory Size Probe

This engine works out how much banked RAM answers on a memory port. A single start pulse runs two passes. The write pass stores a one-byte tag in every bank from the top of the probe range down to the bottom. Each tag is the bank's own number, and every tag sits at the same fixed offset inside its bank. The verify pass then reads the tags back from the bottom bank upward. It stops at the first bank whose tag is wrong and reports the bank just below it as the highest usable bank.

The write order is chosen on purpose. When a bank is only an alias of a lower bank (upper address bits not decoded), the lower bank is written later and overwrites the alias. Reading the alias then returns the lower bank's number, and the alias fails. An undecoded hole that returns a value other than its own number fails in the same way.

The memory side is a plain synchronous port: bank number, fixed offset, write data, write strobe, read strobe, read data and read-valid. Read data may arrive any number of cycles after the read strobe, at least one.

Top module: `bank_size_probe`

## Requirements
- R1: While reset is high, and in the first cycle after it, the outputs `busy_o`, `done_o`, `mem_we_o`, `mem_re_o` and `none_o` are 0 and `last_bank_o` is 0. A reset in the middle of a probe returns the block to idle.
- R2: After start is accepted, the write pass issues exactly one write per cycle on consecutive cycles. The first write goes to bank HI_BANK, each later write goes to the previous bank minus one, and the last write goes to bank LO_BANK. Each write carries the low 8 bits of its bank number as data. The offset is always PROBE_OFS.
- R3: The verify pass begins in the cycle after the last write and reads bank LO_BANK first, then each bank in ascending order. Only one read is outstanding at a time, and each read strobe comes in the cycle after the write pass ended or after read-valid was seen.
- R4: When the read data of bank B (B > LO_BANK) differs from the low 8 bits of B, the probe ends with `last_bank_o` = B-1 and `none_o` = 0. No further read is issued.
- R5: When every bank up to HI_BANK reads back correctly, the probe ends with `last_bank_o` = HI_BANK and `none_o` = 0, after HI_BANK-LO_BANK+1 reads.
- R6: When bank LO_BANK itself mismatches, the probe ends with `none_o` = 1 and `last_bank_o` = 0, after one read.
- R7: A bank that aliases a lower probed bank is reported as beyond the end of memory. A mirror every 16, 32 or 64 banks above banks 0..1 gives a last bank of 0x11, 0x21 or 0x41 for the default range 2..0x7F.
- R8: `done_o` is a single-cycle pulse at the end of each probe, and `busy_o` falls in that same cycle. `busy_o` is high from the cycle after start is accepted until then. The results hold until the next accepted start.
- R9: A start pulse that arrives while `busy_o` is high is ignored. The running probe finishes with one done pulse and no repeated writes.
- R10: `mem_we_o` and `mem_re_o` are never high together, and `mem_re_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Launch a probe when idle |
| mem_bank_o | output | BANK_W | Bank number of the current access |
| mem_ofs_o | output | OFS_W | Offset within the bank (constant PROBE_OFS) |
| mem_wdata_o | output | TAG_W | Tag written to the bank |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| mem_rdata_i | input | TAG_W | Read data |
| mem_rvalid_i | input | 1 | Read data valid |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | One-cycle end-of-probe pulse |
| last_bank_o | output | BANK_W | Highest bank that read back its own tag |
| none_o | output | 1 | Lowest probed bank already failed |

## Verification
If the bank counter steps the wrong way, or a pass starts at the wrong end, the strobes show it at once. The bank on the port departs from the strictly falling write order or the strictly rising read order in the first cycle after the fault. If the comparison or the result selection is wrong, the reported last bank is off for the mirror and hole configurations, and this shows in the done cycle. A controller that re-arms on a start while busy shows a second write burst and a second done pulse within one probe length.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_WAIT  = 2'd2
  } bsp_state_e;
endpackage

// File: rtl/bsp_tag_cmp.sv
module bsp_tag_cmp #(
  parameter int BANK_W = 8,
  parameter int TAG_W  = 8
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [TAG_W-1:0]  rdata_i,
  output logic              match_o
);
  localparam int USE_W = (TAG_W < BANK_W) ? TAG_W : BANK_W;

  logic [TAG_W-1:0] expect_tag;

  generate
    if (TAG_W > BANK_W) begin : g_pad
      assign expect_tag = {{(TAG_W-BANK_W){1'b0}}, bank_i};
    end else begin : g_trunc
      assign expect_tag = bank_i[USE_W-1:0];
    end
  endgenerate

  assign match_o = (rdata_i == expect_tag);
endmodule

// File: rtl/bsp_seq.sv
module bsp_seq
  import bsp_pkg::*;
#(
  parameter int          BANK_W  = 8,
  parameter int          TAG_W   = 8,
  parameter int unsigned LO_BANK = 2,
  parameter int unsigned HI_BANK = 127
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              rvalid_i,
  input  logic              match_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [TAG_W-1:0]  wdata_o,
  output logic              we_o,
  output logic              re_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [BANK_W-1:0] last_o,
  output logic              none_o
);
  localparam logic [BANK_W-1:0] LO = BANK_W'(LO_BANK);
  localparam logic [BANK_W-1:0] HI = BANK_W'(HI_BANK);

  bsp_state_e        st;
  logic [BANK_W-1:0] bank_dn;
  logic [BANK_W-1:0] bank_up;

  assign bank_dn = bank_o - 1'b1;
  assign bank_up = bank_o + 1'b1;

  function automatic logic [TAG_W-1:0] to_tag(input logic [BANK_W-1:0] b);
    return TAG_W'(b);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bank_o  <= '0;
      wdata_o <= '0;
      we_o    <= 1'b0;
      re_o    <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      last_o  <= '0;
      none_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      re_o   <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            st      <= ST_WRITE;
            bank_o  <= HI;
            wdata_o <= to_tag(HI);
            we_o    <= 1'b1;
            busy_o  <= 1'b1;
            last_o  <= '0;
            none_o  <= 1'b0;
          end
        end
        ST_WRITE: begin
          if (bank_o == LO) begin
            we_o <= 1'b0;
            re_o <= 1'b1;
            st   <= ST_WAIT;
          end else begin
            bank_o  <= bank_dn;
            wdata_o <= to_tag(bank_dn);
          end
        end
        ST_WAIT: begin
          if (rvalid_i) begin
            if (match_i && (bank_o != HI)) begin
              bank_o <= bank_up;
              re_o   <= 1'b1;
            end else begin
              st     <= ST_IDLE;
              busy_o <= 1'b0;
              done_o <= 1'b1;
              if (match_i) begin
                last_o <= HI;
              end else if (bank_o == LO) begin
                none_o <= 1'b1;
                last_o <= '0;
              end else begin
                last_o <= bank_dn;
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bank_size_probe.sv
module bank_size_probe #(
  parameter int          BANK_W    = 8,
  parameter int          TAG_W     = 8,
  parameter int          OFS_W     = 12,
  parameter int unsigned PROBE_OFS = 12'h5A6,
  parameter int unsigned LO_BANK   = 2,
  parameter int unsigned HI_BANK   = 127
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic [BANK_W-1:0] mem_bank_o,
  output logic [OFS_W-1:0]  mem_ofs_o,
  output logic [TAG_W-1:0]  mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [TAG_W-1:0]  mem_rdata_i,
  input  logic              mem_rvalid_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BANK_W-1:0] last_bank_o,
  output logic              none_o
);
  logic match;

  assign mem_ofs_o = OFS_W'(PROBE_OFS);

  bsp_tag_cmp #(.BANK_W(BANK_W), .TAG_W(TAG_W)) u_cmp (
    .bank_i  (mem_bank_o),
    .rdata_i (mem_rdata_i),
    .match_o (match)
  );

  bsp_seq #(
    .BANK_W(BANK_W), .TAG_W(TAG_W), .LO_BANK(LO_BANK), .HI_BANK(HI_BANK)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .rvalid_i (mem_rvalid_i),
    .match_i  (match),
    .bank_o   (mem_bank_o),
    .wdata_o  (mem_wdata_o),
    .we_o     (mem_we_o),
    .re_o     (mem_re_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .last_o   (last_bank_o),
    .none_o   (none_o)
  );
endmodule

// File: rtl/bank_size_probe_chk.sv
module bank_size_probe_chk #(
  parameter int BANK_W = 8,
  parameter int TAG_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [BANK_W-1:0] mem_bank_o,
  input logic [TAG_W-1:0]  mem_wdata_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic              mem_rvalid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [BANK_W-1:0] last_bank_o,
  input logic              none_o
);
  p_no_we_re_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_we_o && mem_re_o));

  p_re_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    mem_re_o |=> !mem_re_o);

  p_wr_down_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o)) |-> (mem_bank_o == $past(mem_bank_o) - 1'b1));

  p_wr_tag_r2: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (mem_wdata_o == TAG_W'(mem_bank_o)));

  p_rd_after_r3: assert property (@(posedge clk) disable iff (rst)
    mem_re_o |-> ($past(mem_rvalid_i) || $past(mem_we_o)));

  p_none_zero_r6: assert property (@(posedge clk) disable iff (rst)
    none_o |-> (last_bank_o == '0));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_busy_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !$rose(busy_o) && !done_o && !$past(start_i)) |-> $stable(last_bank_o));

  p_start_ign_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !done_o && !mem_rvalid_i) |=> busy_o);
endmodule

bind bank_size_probe bank_size_probe_chk #(.BANK_W(BANK_W), .TAG_W(TAG_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .mem_bank_o   (mem_bank_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_we_o     (mem_we_o),
  .mem_re_o     (mem_re_o),
  .mem_rvalid_i (mem_rvalid_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .last_bank_o  (last_bank_o),
  .none_o       (none_o)
);

// File: tb/bank_size_probe_bench.sv
module bank_size_probe_bench;
  localparam int BANK_W = 8;
  localparam int TAG_W  = 8;
  localparam int OFS_W  = 12;
  localparam int unsigned PROBE_OFS = 12'h5A6;
  localparam int unsigned LO = 2;
  localparam int unsigned HI = 127;

  // {mirror mask, highest decoded bank, read latency, expected last, expected none}
  localparam logic [39:0] VEC [8] = '{
    {8'hFF, 8'hFF, 8'd1, 8'h7F, 8'd0},
    {8'h1F, 8'hFF, 8'd2, 8'h21, 8'd0},
    {8'h3F, 8'hFF, 8'd1, 8'h41, 8'd0},
    {8'h0F, 8'hFF, 8'd3, 8'h11, 8'd0},
    {8'hFF, 8'h3F, 8'd1, 8'h3F, 8'd0},
    {8'hFF, 8'h01, 8'd2, 8'h00, 8'd1},
    {8'h01, 8'hFF, 8'd1, 8'h03, 8'd0},
    {8'hFF, 8'h02, 8'd1, 8'h02, 8'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [BANK_W-1:0] mbank;
  logic [OFS_W-1:0]  mofs;
  logic [TAG_W-1:0]  mwdata;
  logic mwe, mre, busy, done, none;
  logic [TAG_W-1:0]  mrdata = '0;
  logic mrvalid = 1'b0;
  logic [BANK_W-1:0] last;

  always #2.5 clk = ~clk;

  bank_size_probe #(
    .BANK_W(BANK_W), .TAG_W(TAG_W), .OFS_W(OFS_W), .PROBE_OFS(PROBE_OFS),
    .LO_BANK(LO), .HI_BANK(HI)
  ) u_bank_size_probe (
    .clk(clk), .rst(rst), .start_i(start),
    .mem_bank_o(mbank), .mem_ofs_o(mofs), .mem_wdata_o(mwdata),
    .mem_we_o(mwe), .mem_re_o(mre), .mem_rdata_i(mrdata), .mem_rvalid_i(mrvalid),
    .busy_o(busy), .done_o(done), .last_bank_o(last), .none_o(none)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // memory model and port monitor, both on the falling edge
  logic [7:0] mem [256];
  logic [7:0] mask = 8'hFF;
  logic [7:0] htop = 8'hFF;
  int lat = 1;
  bit pend = 0;
  int pcnt = 0;
  logic [7:0] pbank = '0;
  int wr_cnt = 0, rd_cnt = 0, done_cnt = 0, ord_err = 0, cyc = 0;
  int wr_exp = 0, rd_exp = 0;

  always @(negedge clk) begin
    cyc++;
    mrvalid = 1'b0;
    if (pend) begin
      if (pcnt == 0) begin
        mrvalid = 1'b1;
        mrdata  = (pbank <= htop) ? mem[pbank & mask] : 8'hA5;
        pend    = 0;
      end else pcnt--;
    end
    if (!rst) begin
      if (start && !busy) begin
        wr_exp = HI;
        rd_exp = LO;
      end
      if (mwe) begin
        if (int'(mbank) != wr_exp || mwdata != mbank || mofs != OFS_W'(PROBE_OFS)) ord_err++;
        wr_exp--;
        wr_cnt++;
        if (mbank <= htop) mem[mbank & mask] = mwdata;
      end
      if (mre) begin
        if (int'(mbank) != rd_exp || mofs != OFS_W'(PROBE_OFS)) ord_err++;
        rd_exp++;
        rd_cnt++;
        pend  = 1;
        pcnt  = lat - 1;
        pbank = mbank;
      end
      if (done) done_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit ok;
    int w0, r0, d0, e0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mwe && !mre && !none && last == 0, "R1 reset", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mwe && !mre && !none && last == 0, "R1 after reset", int'(mwe), 0);

    // table walk: R2..R7
    for (int v = 0; v < 8; v++) begin
      clear_mem();
      mask = VEC[v][39:32];
      htop = VEC[v][31:24];
      lat  = int'(VEC[v][23:16]);
      w0 = wr_cnt; r0 = rd_cnt; d0 = done_cnt; e0 = ord_err;
      pulse_start();
      wait_done(ok);
      chk(ok, "R8 done seen", int'(ok), 1);
      @(negedge clk);
      chk(last == VEC[v][15:8], (VEC[v][7:0] != 0) ? "R6 last" : "R7 R4 R5 last",
          int'(last), int'(VEC[v][15:8]));
      chk(none == VEC[v][0], "R6 none", int'(none), int'(VEC[v][0]));
      chk(wr_cnt - w0 == HI - LO + 1, "R2 writes", wr_cnt - w0, HI - LO + 1);
      chk(rd_cnt - r0 == ((VEC[v][0] != 0) ? 1 :
            (VEC[v][15:8] == HI) ? int'(HI - LO + 1) : int'(VEC[v][15:8]) - int'(LO) + 2),
          "R3 R4 R5 reads", rd_cnt - r0, int'(VEC[v][15:8]));
      chk(ord_err == e0, "R2 R3 order", ord_err - e0, 0);
      chk(done_cnt - d0 == 1 && !done && !busy, "R8 pulse", done_cnt - d0, 1);
    end

    // R8 results hold while idle
    repeat (20) @(negedge clk);
    chk(last == 8'h02 && !busy && !done, "R8 hold", int'(last), 2);

    // R9 start while busy is ignored
    clear_mem();
    mask = 8'hFF; htop = 8'hFF; lat = 2;
    w0 = wr_cnt; d0 = done_cnt;
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();
    repeat (150) @(negedge clk);
    pulse_start();
    wait_done(ok);
    repeat (5) @(negedge clk);
    chk(done_cnt - d0 == 1, "R9 one done", done_cnt - d0, 1);
    chk(wr_cnt - w0 == HI - LO + 1, "R9 no rewrite", wr_cnt - w0, HI - LO + 1);
    chk(last == 8'h7F && !busy, "R9 result", int'(last), 127);

    // R1 reset in mid probe
    pulse_start();
    repeat (30) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mwe && !mre && !done && last == 0, "R1 mid reset", int'(busy), 0);
    repeat (10) @(negedge clk);
    chk(!mwe && !mre && !busy, "R1 stays idle", int'(mwe), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule